// File: doc/BRIEF.md
# Byte-Wide Configuration Loader

This block loads a programmable device through its byte-wide slave parallel configuration port. A one-cycle `start` opens a load. The loader gives a one-cycle pre-load hook pulse and drives the program line low for a fixed number of cycles. It then waits for the device to report that it is ready. Once ready, the loader holds the active-low chip select and write strobe low for the whole stream.

Bytes arrive on a ready/valid input and are sent in a continuous stream. A byte marked last ends the stream. Each byte is placed on the data bus first. The configuration clock, which idles high, then makes one low/high pulse. Its rising edge carries the byte into the device. When the busy check is built in, a busy response after a pulse repeats the pulse with the same byte until busy clears.

After the stream, the loader releases chip select and then the write strobe. It keeps pulsing the clock until the device signals done. Each wait is bounded by a cycle timeout. When a timeout expires, the loader aborts and records which wait failed. A post-load hook pulse closes every load, whether it succeeds or fails.

Top module: `bitcfg_par_master`

## Requirements
- R1: In idle, a sampled `start` gives a one-cycle `preHook` pulse and drives `cfgProgN` low for exactly PROG_CYCLES cycles, both starting in the following cycle.
- R2: After the program release, `cfgCsN` and `cfgWrN` both fall at the first clock edge that samples `cfgInitN`=1 and `cfgBusy`=0. This readiness must be seen within TIMEOUT_CYCLES+1 edges after the release. Otherwise the load fails with status 1.
- R3: `cfgCsN` and `cfgWrN` stay low from that point until the stream ends. `inReady` is high only while both are low. `cfgClk` is high whenever no pulse is in progress.
- R4: A handshake (`inValid` and `inReady`) loads the byte onto `cfgData`. CLK_DIV cycles later `cfgClk` goes low for CLK_DIV cycles, then it goes high for CLK_DIV cycles. `cfgData` is stable at every rising edge of `cfgClk`.
- R5: With BUSY_CHECK=1, `cfgBusy` may be sampled high at the end of a byte's high phase. In that case another pulse follows with the same byte. If busy is still high once the cycles since the handshake reach TIMEOUT_CYCLES+1, the load fails with status 2.
- R6: With BUSY_CHECK=0, `cfgBusy` has no effect during the stream: every byte gets exactly one pulse.
- R7: After the last byte's pulse, `cfgCsN` rises one cycle before `cfgWrN`.
- R8: After the write strobe is released, `cfgDone` is sampled at the end of each high phase. If it is low, a new pulse follows. If done is still low once TIMEOUT_CYCLES+1 cycles have passed since the release, the load fails with status 3.
- R9: Every load ends with a one-cycle `postHook` pulse, and `active` falls at the same time. `status` is 0 on success. On failure, `abort` pulses with `postHook`, and the strobes and clock return high. `status` holds its value until the next start.
- R10: `start` is ignored while `active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (sampled in idle only) |
| inData | input | DATA_W | Stream byte |
| inValid | input | 1 | Stream byte valid |
| inLast | input | 1 | Marks the final byte of the stream |
| inReady | output | 1 | Loader accepts a byte this cycle |
| cfgInitN | input | 1 | Device init line, high when ready |
| cfgBusy | input | 1 | Device busy, high when not accepting |
| cfgDone | input | 1 | Device configuration complete |
| cfgProgN | output | 1 | Active-low program pulse |
| cfgCsN | output | 1 | Active-low chip select |
| cfgWrN | output | 1 | Active-low write strobe |
| cfgClk | output | 1 | Configuration clock, idles high |
| cfgData | output | DATA_W | Configuration data bus |
| preHook | output | 1 | One-cycle pulse at load start |
| postHook | output | 1 | One-cycle pulse at load end |
| abort | output | 1 | One-cycle pulse on a failed load |
| active | output | 1 | Load in progress |
| status | output | 2 | 0 ok, 1 ready timeout, 2 busy timeout, 3 done timeout |

## Verification
Some rules hold on every cycle, and the assertions check them:
- the bus stays stable across each rising edge of the configuration clock;
- chip select is released before the write strobe;
- `inReady` appears only under asserted strobes;
- the pins return to idle whenever no load is running;
- abort comes with the post hook.

Other behaviour needs a scenario to show it. This covers the exact program width, how many pulses a busy stall adds, and the timeout edge for each of the three waits. It also covers the difference between the two busy-check variants and a `start` ignored in mid-load. The bench's cycle model and its status checks cover these.

// File: rtl/bitcfg_pkg.sv
package bitcfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WAITRDY, S_FETCH, S_SETTLE, S_PLO, S_PHI, S_RELWR
  } state_t;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_RDY_TO  = 2'd1;
  localparam logic [1:0] ST_BUSY_TO = 2'd2;
  localparam logic [1:0] ST_DONE_TO = 2'd3;

  // one-cycle commands from control to the pin datapath
  typedef struct packed {
    logic       preFire;
    logic       progOn;
    logic       progOff;
    logic       busOn;
    logic       csOff;
    logic       wrOff;
    logic       clkLow;
    logic       clkHigh;
    logic       loadByte;
    logic       clearStatus;
    logic       finish;
    logic       fail;
    logic [1:0] code;
  } strobe_t;

endpackage

// File: rtl/bitcfg_ctrl.sv
module bitcfg_ctrl
  import bitcfg_pkg::*;
#(
  parameter int CLK_DIV        = 3,
  parameter int PROG_CYCLES    = 128,
  parameter int TIMEOUT_CYCLES = 2500000,
  parameter bit BUSY_CHECK     = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    cfgInitN,
  input  logic    cfgBusy,
  input  logic    cfgDone,
  output logic    inReady,
  output logic    active,
  output strobe_t st
);

  localparam int CMAX = (PROG_CYCLES > CLK_DIV) ? PROG_CYCLES : CLK_DIV;
  localparam int CW   = $clog2(CMAX + 1) + 1;
  localparam int TW   = $clog2(TIMEOUT_CYCLES + 1) + 1;

  state_t        state, stateNext;
  logic [CW-1:0] cnt, cntNext;
  logic [TW-1:0] timer, timerNext;
  logic          lastFlag, lastNext;
  logic          doneMode, doneNext;
  logic          busyStall;
  logic          timerExp, divHit, progHit;

  // elaboration-time choice of whether busy can stall the stream
  generate
    if (BUSY_CHECK) begin : g_busyOn
      assign busyStall = cfgBusy;
    end else begin : g_busyOff
      assign busyStall = 1'b0;
    end
  endgenerate

  assign timerExp = (timer >= TW'(TIMEOUT_CYCLES));
  assign divHit   = (cnt == CW'(CLK_DIV - 1));
  assign progHit  = (cnt == CW'(PROG_CYCLES - 1));
  assign active   = (state != S_IDLE);

  always_comb begin
    st        = '0;
    stateNext = state;
    cntNext   = cnt;
    timerNext = timerExp ? timer : timer + 1'b1;
    lastNext  = lastFlag;
    doneNext  = doneMode;
    inReady   = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        st.preFire = 1'b1; st.progOn = 1'b1; st.clearStatus = 1'b1;
        cntNext = '0; doneNext = 1'b0; stateNext = S_PROG;
      end
      S_PROG: if (progHit) begin
        st.progOff = 1'b1; cntNext = '0; timerNext = '0; stateNext = S_WAITRDY;
      end else cntNext = cnt + 1'b1;
      S_WAITRDY: if (cfgInitN && !cfgBusy) begin
        st.busOn = 1'b1; stateNext = S_FETCH;
      end else if (timerExp) begin
        st.finish = 1'b1; st.fail = 1'b1; st.code = ST_RDY_TO; stateNext = S_IDLE;
      end
      S_FETCH: begin
        inReady = 1'b1;
        if (inValid) begin
          st.loadByte = 1'b1; lastNext = inLast; cntNext = '0; timerNext = '0;
          stateNext = S_SETTLE;
        end
      end
      S_SETTLE: if (divHit) begin
        st.clkLow = 1'b1; cntNext = '0; stateNext = S_PLO;
      end else cntNext = cnt + 1'b1;
      S_PLO: if (divHit) begin
        st.clkHigh = 1'b1; cntNext = '0; stateNext = S_PHI;
      end else cntNext = cnt + 1'b1;
      S_PHI: if (!divHit) cntNext = cnt + 1'b1;
      else begin
        cntNext = '0;
        if (doneMode) begin
          if (cfgDone) begin
            st.finish = 1'b1; st.code = ST_OK; stateNext = S_IDLE;
          end else if (timerExp) begin
            st.finish = 1'b1; st.fail = 1'b1; st.code = ST_DONE_TO; stateNext = S_IDLE;
          end else begin
            st.clkLow = 1'b1; stateNext = S_PLO;
          end
        end else if (busyStall) begin
          if (timerExp) begin
            st.finish = 1'b1; st.fail = 1'b1; st.code = ST_BUSY_TO; stateNext = S_IDLE;
          end else begin
            st.clkLow = 1'b1; stateNext = S_PLO;
          end
        end else if (lastFlag) begin
          st.csOff = 1'b1; stateNext = S_RELWR;
        end else stateNext = S_FETCH;
      end
      S_RELWR: begin
        st.wrOff = 1'b1; doneNext = 1'b1; timerNext = '0; cntNext = '0;
        stateNext = S_PHI;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; cnt <= '0; timer <= '0; lastFlag <= 1'b0; doneMode <= 1'b0;
    end else begin
      state <= stateNext; cnt <= cntNext; timer <= timerNext;
      lastFlag <= lastNext; doneMode <= doneNext;
    end
  end

endmodule

// File: rtl/bitcfg_datapath.sv
module bitcfg_datapath
  import bitcfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] inData,
  output logic              cfgProgN,
  output logic              cfgCsN,
  output logic              cfgWrN,
  output logic              cfgClk,
  output logic [DATA_W-1:0] cfgData,
  output logic              preHook,
  output logic              postHook,
  output logic              abort,
  output logic [1:0]        status
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgProgN <= 1'b1; cfgCsN <= 1'b1; cfgWrN <= 1'b1; cfgClk <= 1'b1;
      cfgData <= '0; preHook <= 1'b0; postHook <= 1'b0; abort <= 1'b0;
      status <= ST_OK;
    end else begin
      preHook  <= st.preFire;
      postHook <= st.finish;
      abort    <= st.fail;
      if (st.progOn)      cfgProgN <= 1'b0;
      if (st.progOff)     cfgProgN <= 1'b1;
      if (st.busOn)       begin cfgCsN <= 1'b0; cfgWrN <= 1'b0; end
      if (st.csOff)       cfgCsN <= 1'b1;
      if (st.wrOff)       cfgWrN <= 1'b1;
      if (st.clkLow)      cfgClk <= 1'b0;
      if (st.clkHigh)     cfgClk <= 1'b1;
      if (st.loadByte)    cfgData <= inData;
      if (st.clearStatus) status <= ST_OK;
      if (st.finish)      status <= st.code;
      if (st.fail)        begin cfgCsN <= 1'b1; cfgWrN <= 1'b1; cfgClk <= 1'b1; end
    end
  end

  // R4: the byte never moves across a rising configuration clock
  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> $stable(cfgData));

  // R7: on a normal end, chip select went high the cycle before the write strobe
  assert_cs_before_wr_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cfgWrN) && !abort) |-> ($past(cfgCsN) && !$past(cfgCsN, 2)));

  // R9: the post hook is a single-cycle pulse
  assert_post_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    postHook |=> !postHook);

endmodule

// File: rtl/bitcfg_par_master.sv
module bitcfg_par_master
  import bitcfg_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int CLK_DIV        = 3,
  parameter int PROG_CYCLES    = 128,
  parameter int TIMEOUT_CYCLES = 2500000,
  parameter bit BUSY_CHECK     = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  input  logic              cfgInitN,
  input  logic              cfgBusy,
  input  logic              cfgDone,
  output logic              cfgProgN,
  output logic              cfgCsN,
  output logic              cfgWrN,
  output logic              cfgClk,
  output logic [DATA_W-1:0] cfgData,
  output logic              preHook,
  output logic              postHook,
  output logic              abort,
  output logic              active,
  output logic [1:0]        status
);

  strobe_t st;

  bitcfg_ctrl #(
    .CLK_DIV(CLK_DIV), .PROG_CYCLES(PROG_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .BUSY_CHECK(BUSY_CHECK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inLast(inLast),
    .cfgInitN(cfgInitN), .cfgBusy(cfgBusy), .cfgDone(cfgDone),
    .inReady(inReady), .active(active), .st(st)
  );

  bitcfg_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData),
    .cfgProgN(cfgProgN), .cfgCsN(cfgCsN), .cfgWrN(cfgWrN), .cfgClk(cfgClk),
    .cfgData(cfgData), .preHook(preHook), .postHook(postHook), .abort(abort),
    .status(status)
  );

  // R3: bytes are only taken while both strobes are held low
  assert_ready_under_strobes_R3: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!cfgCsN && !cfgWrN && cfgProgN));

  // R9: outside a load every pin sits at its idle level
  assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (cfgCsN && cfgWrN && cfgClk && cfgProgN));

  // R1: the program pulse only happens inside a load
  assert_prog_in_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgProgN |-> active);

  // R9: a failure always closes with the post hook and a nonzero status
  assert_abort_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> (postHook && status != ST_OK));

endmodule

// File: tb/bitcfg_par_master_tb.sv
module bitcfg_par_master_tb;

  localparam int DW = 8;
  localparam int D  = 2;
  localparam int P  = 4;
  localparam int T  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  // main instance (busy check on)
  logic          start = 0, inValid = 0, inLast = 0;
  logic [DW-1:0] inData = '0;
  logic          cfgInitN = 1, cfgBusy = 0, cfgDone = 0;
  logic          inReady, cfgProgN, cfgCsN, cfgWrN, cfgClk, preHook, postHook, abort, active;
  logic [DW-1:0] cfgData;
  logic [1:0]    status;

  bitcfg_par_master #(.DATA_W(DW), .CLK_DIV(D), .PROG_CYCLES(P),
                      .TIMEOUT_CYCLES(T), .BUSY_CHECK(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .cfgInitN(cfgInitN), .cfgBusy(cfgBusy),
    .cfgDone(cfgDone), .cfgProgN(cfgProgN), .cfgCsN(cfgCsN), .cfgWrN(cfgWrN),
    .cfgClk(cfgClk), .cfgData(cfgData), .preHook(preHook), .postHook(postHook),
    .abort(abort), .active(active), .status(status));

  // second instance (busy check off)
  logic          startB = 0, inValidB = 0, inLastB = 0;
  logic [DW-1:0] inDataB = '0;
  logic          inReadyB, progNB, csNB, wrNB, clkB, preB, postB, abortB, activeB;
  logic [DW-1:0] dataB;
  logic [1:0]    statusB;
  logic          busyB, doneB;
  assign busyB = !csNB;
  assign doneB = csNB && wrNB;

  bitcfg_par_master #(.DATA_W(DW), .CLK_DIV(D), .PROG_CYCLES(P),
                      .TIMEOUT_CYCLES(T), .BUSY_CHECK(1'b0)) u_dutNb (
    .clk(clk), .rstN(rstN), .start(startB), .inData(inDataB), .inValid(inValidB),
    .inLast(inLastB), .inReady(inReadyB), .cfgInitN(1'b1), .cfgBusy(busyB),
    .cfgDone(doneB), .cfgProgN(progNB), .cfgCsN(csNB), .cfgWrN(wrNB),
    .cfgClk(clkB), .cfgData(dataB), .preHook(preB), .postHook(postB),
    .abort(abortB), .active(activeB), .status(statusB));

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int initHold = 0, busyByte = -1, busyLen = 0, doneDelay = 0;
  int initCnt = 1000000, riseCnt = 0, busyLeft = 0, doneCnt = 0;
  bit streamed = 0, prevClk = 1;

  always @(negedge clk) begin
    if (!cfgProgN) begin
      initCnt = 0; cfgInitN <= 1'b0; riseCnt = 0; busyLeft = 0; doneCnt = 0; streamed = 0;
    end else if (initCnt < initHold) begin
      initCnt++; cfgInitN <= 1'b0;
    end else cfgInitN <= 1'b1;
    if (cfgClk && !prevClk && !cfgCsN) begin
      riseCnt++;
      if (riseCnt == busyByte) busyLeft = busyLen;
    end
    prevClk = cfgClk;
    cfgBusy <= (busyLeft > 0);
    if (busyLeft > 0) busyLeft--;
    if (!cfgCsN) streamed = 1;
    if (streamed && cfgWrN && cfgCsN && cfgProgN) doneCnt++;
    cfgDone <= (doneDelay >= 0) && streamed && (doneCnt > doneDelay);
  end

  // ---------------- behavioural reference ----------------
  logic          eProgN = 1, eCsN = 1, eWrN = 1, eClk = 1, ePre = 0, ePost = 0;
  logic          eAbort = 0, eActive = 0, eReady = 0;
  logic [DW-1:0] eData = '0;
  logic [1:0]    eStatus = 0;
  bit            modelOn = 0;

  task automatic mstep();
    @(posedge clk);
    #1;
    ePre = 0; ePost = 0; eAbort = 0;
  endtask

  initial begin
    wait (rstN);
    modelOn = 1;
    forever begin
      int code, k, n;
      bit last;
      do mstep(); while (!start);
      ePre = 1; eProgN = 0; eActive = 1; eStatus = 0;
      repeat (P) mstep();
      eProgN = 1;
      code = 0; k = 0;
      forever begin
        mstep(); k++;
        if (cfgInitN && !cfgBusy) begin eCsN = 0; eWrN = 0; break; end
        if (k - 1 >= T) begin code = 1; break; end
      end
      if (code == 0) begin
        forever begin
          eReady = 1;
          do mstep(); while (!inValid);
          eReady = 0; eData = inData; last = inLast; n = 0;
          repeat (D) mstep();
          eClk = 0;
          repeat (D) mstep();
          eClk = 1;
          repeat (D) mstep();
          n = 3 * D;
          while (cfgBusy) begin
            if (n - 1 >= T) begin code = 2; break; end
            eClk = 0;
            repeat (D) mstep();
            eClk = 1;
            repeat (D) mstep();
            n += 2 * D;
          end
          if (code != 0) break;
          if (last) begin eCsN = 1; break; end
        end
      end
      if (code == 0) begin
        mstep();
        eWrN = 1; n = 0;
        forever begin
          repeat (D) mstep();
          n += D;
          if (cfgDone) break;
          if (n - 1 >= T) begin code = 3; break; end
          eClk = 0;
          repeat (D) mstep();
          eClk = 1; n += D;
        end
      end
      ePost = 1; eActive = 0; eStatus = code[1:0]; eReady = 0;
      if (code != 0) begin eAbort = 1; eCsN = 1; eWrN = 1; eClk = 1; end
    end
  end

  task automatic cmp(input string what, input int act, input int exp, inout bit bad);
    if (act != exp) begin
      bad = 1;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn) begin
      bit bad = 0;
      checks++;
      cmp("R1 cfgProgN", cfgProgN, eProgN, bad);
      cmp("R1 preHook", preHook, ePre, bad);
      cmp("R3 cfgCsN", cfgCsN, eCsN, bad);
      cmp("R7 cfgWrN", cfgWrN, eWrN, bad);
      cmp("R4 cfgClk", cfgClk, eClk, bad);
      cmp("R4 cfgData", cfgData, eData, bad);
      cmp("R4 inReady", inReady, eReady, bad);
      cmp("R9 postHook", postHook, ePost, bad);
      cmp("R9 abort", abort, eAbort, bad);
      cmp("R9 active", active, eActive, bad);
      cmp("R9 status", status, eStatus, bad);
      if (bad) errors++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic runLoad(input int nBytes, input int gap, input bit glitch, input int seed);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < nBytes; i++) begin
      repeat (gap) @(negedge clk);
      inValid = 1; inData = DW'(seed + i * 37); inLast = (i == nBytes - 1);
      start = glitch && (i == 1);   // R10: start pulse mid-load
      while (!inReady && active) @(negedge clk);
      if (!active) break;
      @(posedge clk);
      @(negedge clk);
      inValid = 0; inLast = 0; start = 0;
    end
    inValid = 0; inLast = 0; start = 0;
    while (active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state
    check(cfgProgN && cfgCsN && cfgWrN && cfgClk, "R9 idle pins after reset", {cfgProgN, cfgCsN, cfgWrN, cfgClk}, 15);
    check(status == 0 && !active && !inReady, "R9 reset status/active", status, 0);

    // A: plain load, start glitch mid-load
    initHold = 3; busyByte = -1; doneDelay = 5;
    runLoad(4, 0, 1'b1, 8'h11);
    check(status == 0, "R8 status after good load", status, 0);
    check(!active, "R10 mid-load start ignored, no new load", active, 0);

    // B: busy stall on second byte, gaps between bytes
    initHold = 2; busyByte = 2; busyLen = 15; doneDelay = 2;
    runLoad(5, 3, 1'b0, 8'h5A);
    check(status == 0, "R5 status after stalled load", status, 0);

    // C: device never ready
    initHold = 1000; busyByte = -1;
    runLoad(2, 0, 1'b0, 8'h20);
    check(status == 1, "R2 ready timeout status", status, 1);
    initHold = 0;
    repeat (5) @(negedge clk);
    check(status == 1, "R9 status held in idle", status, 1);

    // D: busy never clears
    busyByte = 1; busyLen = 1000; doneDelay = 0;
    runLoad(3, 0, 1'b0, 8'h33);
    check(status == 2, "R5 busy timeout status", status, 2);

    // E: done never comes
    busyByte = -1; doneDelay = -1;
    runLoad(2, 1, 1'b0, 8'h44);
    check(status == 3, "R8 done timeout status", status, 3);

    // F: immediate done, single byte
    doneDelay = 0;
    runLoad(1, 0, 1'b0, 8'hC3);
    check(status == 0, "R9 status cleared by new start", status, 0);

    // G: busy ignored with the check disabled
    begin
      int rises = 0;
      bit pc = 1;
      @(negedge clk) startB = 1;
      @(negedge clk) startB = 0;
      fork
        begin
          while (!activeB) @(negedge clk);
          while (activeB) begin
            @(negedge clk);
            if (clkB && !pc && !csNB) rises++;
            pc = clkB;
          end
        end
        begin
          for (int i = 0; i < 3; i++) begin
            inValidB = 1; inDataB = DW'(8'h70 + i); inLastB = (i == 2);
            while (!inReadyB) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            inValidB = 0; inLastB = 0;
          end
        end
      join
      check(rises == 3, "R6 one pulse per byte with busy high", rises, 3);
      check(statusB == 0, "R6 status without busy check", statusB, 0);
    end

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule